// File: doc/BRIEF.md
# PCIe Controller Client Register Block

This block sits next to a PCIe controller core and gives software a small register window over it. Through that window software picks root-complex or endpoint mode and turns link training on or off. It can also read the live training state and the link flags. Two interrupt groups are served. The four legacy INTx lines are gathered into a status register with a mask. Link-up edges and reset requests from the core are captured as sticky events with their own mask. Each group drives one combined interrupt output.

The control, mask and hot-reset registers are written through a per-bit write mask. The upper halfword of a write selects which of the lower sixteen bits change, so software never needs a read-modify-write. When the training-delay option is on, a hot reset or link-down reset request from the core puts a hold on link training. The hold stays in place until software writes the release bit. Reads are combinational from the address. A write takes effect at the clock edge on which it is presented.

Top module: `pcie_glue_regs`

## Requirements
- R1: In the control (0x000), legacy mask (0x01C), misc mask (0x024) and hot-reset (0x180) registers, a lower bit n (n < 16) of the register changes on a write only when write bit n+16 is 1 in the same write. Otherwise it keeps its value.
- R2: The control register at 0x000 holds the mode in bits 7:4 (0x0 endpoint, 0x4 root complex) and the training enable in bit 2. Both reset to 0. The mode field drives `mode_o`.
- R3: A read of 0x300 returns the core's training state in bits 5:0, the physical link flag in bit 16 and the data-link flag in bit 17. A value of 2'b11 in bits 17:16 means the link is up.
- R4: The misc status register at 0x010 sets bit 1 on a rising edge of `link_dl_i` and bit 2 on a `rst_req_i` pulse. Both bits are sticky. Writing 1 to a bit clears it. A set and a clear in the same cycle leave the bit set.
- R5: The misc mask at 0x024 resets to 0xFFFF (all masked). `misc_irq_o` is high when any misc status bit is set while its mask bit is 0.
- R6: Bits 3:0 of the legacy status register at 0x008 show `intx_i[3:0]` one cycle late. The legacy mask at 0x01C is 8 bits and resets to 0xFF. `intx_irq_o` is high when any status bit n is set while mask bit n is 0.
- R7: In the hot-reset register, bit 1 enables the training delay and bit 4 enables enhanced control. While the delay is enabled, `rst_req_i` sets `train_hold_o` at the next edge. A write with bits 3 and 19 both 1 clears the hold. A request in the same cycle wins over a release. Bit 3 always reads 0.
- R8: `ltssm_en_o` equals control bit 2 AND NOT (`train_hold_o` AND hot-reset bit 4).
- R9: Reads of undefined offsets return 0, and unimplemented bits of defined registers read 0.
- R10: With the delay enable (hot-reset bit 1) clear, a `rst_req_i` pulse leaves `train_hold_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Write strobe for one cycle |
| reg_addr_i | input | ADDR_W | Byte offset of the access |
| reg_wdata_i | input | 32 | Write data, upper half is the write mask |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| ltssm_state_i | input | LTSSM_W | Current training state from the core |
| link_phys_i | input | 1 | Physical layer link-up flag |
| link_dl_i | input | 1 | Data-link layer link-up flag |
| intx_i | input | INTX_N | Legacy INTA..INTD levels |
| rst_req_i | input | 1 | Hot or link-down reset request pulse |
| mode_o | output | 4 | Device mode field |
| ltssm_en_o | output | 1 | Training enable to the core |
| train_hold_o | output | 1 | Training hold after a reset request |
| misc_irq_o | output | 1 | Combined misc event interrupt |
| intx_irq_o | output | 1 | Combined legacy interrupt |

## Verification
The bench uses the default build: a 12-bit address, 6-bit training state, four INTx lines and an 8-bit legacy mask. With these values every defined offset is reachable, along with unused gaps such as 0x004 and 0x200. The whole mask width can be driven, which includes mask bits 7:4 that have no INTx line behind them. The four-line width lets random traffic cover every mix of pending and masked legacy lines. It also reaches the cases where the hold and a release, or an event set and its clear, fall in the same cycle.

// File: rtl/glue_pkg.sv
package glue_pkg;
  localparam int unsigned OFS_W = 12;

  localparam logic [OFS_W-1:0] OFS_CTRL    = 12'h000;
  localparam logic [OFS_W-1:0] OFS_INTX_ST = 12'h008;
  localparam logic [OFS_W-1:0] OFS_MSTAT   = 12'h010;
  localparam logic [OFS_W-1:0] OFS_IMASK   = 12'h01C;
  localparam logic [OFS_W-1:0] OFS_MMASK   = 12'h024;
  localparam logic [OFS_W-1:0] OFS_HOT     = 12'h180;
  localparam logic [OFS_W-1:0] OFS_LTSSM   = 12'h300;

  localparam int unsigned CTRL_EN_BIT  = 2;
  localparam int unsigned MODE_LSB     = 4;
  localparam int unsigned MODE_W       = 4;
  localparam int unsigned EV_LINK_BIT  = 1;
  localparam int unsigned EV_RST_BIT   = 2;
  localparam int unsigned HOT_DLY_BIT  = 1;
  localparam int unsigned HOT_DONE_BIT = 3;
  localparam int unsigned HOT_ENH_BIT  = 4;
  localparam int unsigned LNK_PHYS_BIT = 16;
  localparam int unsigned LNK_DL_BIT   = 17;

  localparam logic [15:0] CTRL_IMPL  = 16'h00F4;
  localparam logic [15:0] HOT_IMPL   = 16'h0012;
  localparam logic [15:0] MSTAT_IMPL = 16'h0006;
endpackage

// File: rtl/glue_wmreg.sv
module glue_wmreg #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] RST  = '0,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [31:0]  wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] en;
  logic [W-1:0] q_q;

  assign en = wdata_i[16 +: W] & IMPL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= RST & IMPL;
    else if (we_i) q_q <= (q_q & ~en) | (wdata_i[W-1:0] & en);
  end

  assign q_o = q_q;

  // bits without their enable never move
  p_masked_keep_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (wdata_i[16 +: W] == '0)) |=> $stable(q_o));
endmodule

// File: rtl/glue_evt.sv
module glue_evt #(
  parameter int unsigned  W    = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] st_o,
  output logic         irq_o
);
  logic [W-1:0] st_q;
  logic [W-1:0] st_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_live
      assign st_d[i] = set_i[i] | (st_q[i] & ~(clr_we_i & clr_i[i]));
    end else begin : g_tied
      assign st_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign st_o  = st_q;
  assign irq_o = |(st_q & ~mask_i);

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((st_q & $past(st_q)) == $past(st_q)));
  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(set_i & IMPL) |=> ((st_q & $past(set_i & IMPL)) == $past(set_i & IMPL)));
endmodule

// File: rtl/glue_hold.sv
module glue_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dly_en_i,
  input  logic req_i,
  input  logic rel_i,
  output logic hold_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hold_q <= 1'b0;
    else if (dly_en_i && req_i) hold_q <= 1'b1;
    else if (rel_i)             hold_q <= 1'b0;
  end

  assign hold_o = hold_q;

  p_hold_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_en_i && req_i) |=> hold_o);
  p_hold_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !rel_i) |=> hold_o);
  p_no_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && !(dly_en_i && req_i)) |=> !hold_o);
endmodule

// File: rtl/pcie_glue_regs.sv
module pcie_glue_regs
  import glue_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned LTSSM_W = 6,
  parameter int unsigned INTX_N  = 4,
  parameter int unsigned IMASK_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [LTSSM_W-1:0] ltssm_state_i,
  input  logic               link_phys_i,
  input  logic               link_dl_i,
  input  logic [INTX_N-1:0]  intx_i,
  input  logic               rst_req_i,
  output logic [MODE_W-1:0]  mode_o,
  output logic               ltssm_en_o,
  output logic               train_hold_o,
  output logic               misc_irq_o,
  output logic               intx_irq_o
);
  localparam logic [IMASK_W-1:0] IMASK_RST = '1;
  localparam logic [15:0]        MMASK_RST = '1;

  logic [OFS_W-1:0] ofs;
  assign ofs = OFS_W'(reg_addr_i);

  logic we_ctrl, we_imask, we_mmask, we_hot, we_mstat;
  assign we_ctrl  = reg_we_i && (ofs == OFS_CTRL);
  assign we_imask = reg_we_i && (ofs == OFS_IMASK);
  assign we_mmask = reg_we_i && (ofs == OFS_MMASK);
  assign we_hot   = reg_we_i && (ofs == OFS_HOT);
  assign we_mstat = reg_we_i && (ofs == OFS_MSTAT);

  logic [15:0]        ctrl_q, hot_q, mmask_q, mstat_q;
  logic [IMASK_W-1:0] imask_q;

  glue_wmreg #(.W(16), .RST(16'h0000), .IMPL(CTRL_IMPL)) u_ctrl (
    .clk_i, .rst_ni, .we_i(we_ctrl), .wdata_i(reg_wdata_i), .q_o(ctrl_q));
  glue_wmreg #(.W(16), .RST(16'h0000), .IMPL(HOT_IMPL)) u_hot (
    .clk_i, .rst_ni, .we_i(we_hot), .wdata_i(reg_wdata_i), .q_o(hot_q));
  glue_wmreg #(.W(16), .RST(MMASK_RST), .IMPL(16'hFFFF)) u_mmask (
    .clk_i, .rst_ni, .we_i(we_mmask), .wdata_i(reg_wdata_i), .q_o(mmask_q));
  glue_wmreg #(.W(IMASK_W), .RST(IMASK_RST), .IMPL('1)) u_imask (
    .clk_i, .rst_ni, .we_i(we_imask), .wdata_i(reg_wdata_i), .q_o(imask_q));

  // link-up edge detect
  logic dl_prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dl_prev_q <= 1'b0;
    else         dl_prev_q <= link_dl_i;
  end

  logic [15:0] ev_set;
  always_comb begin
    ev_set              = '0;
    ev_set[EV_LINK_BIT] = link_dl_i & ~dl_prev_q;
    ev_set[EV_RST_BIT]  = rst_req_i;
  end

  glue_evt #(.W(16), .IMPL(MSTAT_IMPL)) u_misc (
    .clk_i, .rst_ni, .set_i(ev_set), .clr_we_i(we_mstat),
    .clr_i(reg_wdata_i[15:0]), .mask_i(mmask_q), .st_o(mstat_q), .irq_o(misc_irq_o));

  // legacy lines: level, registered once
  logic [INTX_N-1:0] intx_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) intx_q <= '0;
    else         intx_q <= intx_i;
  end
  assign intx_irq_o = |(intx_q & ~imask_q[INTX_N-1:0]);

  logic hot_rel;
  assign hot_rel = we_hot && reg_wdata_i[16+HOT_DONE_BIT] && reg_wdata_i[HOT_DONE_BIT];

  glue_hold u_hold (
    .clk_i, .rst_ni, .dly_en_i(hot_q[HOT_DLY_BIT]), .req_i(rst_req_i),
    .rel_i(hot_rel), .hold_o(train_hold_o));

  assign mode_o     = ctrl_q[MODE_LSB +: MODE_W];
  assign ltssm_en_o = ctrl_q[CTRL_EN_BIT] & ~(train_hold_o & hot_q[HOT_ENH_BIT]);

  always_comb begin
    reg_rdata_o = '0;
    unique case (ofs)
      OFS_CTRL:    reg_rdata_o[15:0]          = ctrl_q;
      OFS_INTX_ST: reg_rdata_o[INTX_N-1:0]    = intx_q;
      OFS_MSTAT:   reg_rdata_o[15:0]          = mstat_q;
      OFS_IMASK:   reg_rdata_o[IMASK_W-1:0]   = imask_q;
      OFS_MMASK:   reg_rdata_o[15:0]          = mmask_q;
      OFS_HOT:     reg_rdata_o[15:0]          = hot_q;
      OFS_LTSSM: begin
        reg_rdata_o[LTSSM_W-1:0]  = ltssm_state_i;
        reg_rdata_o[LNK_PHYS_BIT] = link_phys_i;
        reg_rdata_o[LNK_DL_BIT]   = link_dl_i;
      end
      default:     reg_rdata_o = '0;
    endcase
  end

  p_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (train_hold_o && hot_q[HOT_ENH_BIT]) |-> !ltssm_en_o);
endmodule

// File: tb/pcie_glue_regs_tb.sv
module pcie_glue_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic [5:0]  st = '0;
  logic        phys = 1'b0, dl = 1'b0, rq = 1'b0;
  logic [3:0]  ix = '0;
  logic [3:0]  mode;
  logic        ltssm_en, hold, mirq, iirq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pcie_glue_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_rdata_o(rd), .ltssm_state_i(st), .link_phys_i(phys), .link_dl_i(dl),
    .intx_i(ix), .rst_req_i(rq), .mode_o(mode), .ltssm_en_o(ltssm_en),
    .train_hold_o(hold), .misc_irq_o(mirq), .intx_irq_o(iirq));

  // reference model state
  logic [15:0] m_ctrl = 16'h0, m_hot = 16'h0, m_mmask = 16'hFFFF, m_mst = 16'h0;
  logic [7:0]  m_imask = 8'hFF;
  logic [3:0]  m_ix = '0;
  logic        m_hold = 1'b0, m_prev = 1'b0;

  function automatic logic [15:0] wm(logic [15:0] old, logic [31:0] d, logic [15:0] impl);
    logic [15:0] en;
    en = d[31:16] & impl;
    return (old & ~en) | (d[15:0] & en);
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    case (a)
      12'h000: return {16'h0, m_ctrl};
      12'h008: return {28'h0, m_ix};
      12'h010: return {16'h0, m_mst};
      12'h01C: return {24'h0, m_imask};
      12'h024: return {16'h0, m_mmask};
      12'h180: return {16'h0, m_hot};
      12'h300: return {14'h0, dl, phys, 10'h0, st};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [11:0] a);
    case (a)
      12'h000: return "R2";
      12'h008: return "R6";
      12'h010: return "R4";
      12'h01C: return "R6";
      12'h024: return "R5";
      12'h180: return "R7";
      12'h300: return "R3";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_all();
    chk("R2", 32'(mode), 32'(m_ctrl[7:4]));
    chk("R8", 32'(ltssm_en), 32'(m_ctrl[2] & ~(m_hold & m_hot[4])));
    chk("R7", 32'(hold), 32'(m_hold));
    chk("R5", 32'(mirq), 32'(|(m_mst & ~m_mmask)));
    chk("R6", 32'(iirq), 32'(|(m_ix & ~m_imask[3:0])));
    chk(tag_of(addr), rd, m_read(addr));
  endtask

  // one clock: drive at negedge, model next state, check after posedge
  task automatic cyc(logic w, logic [11:0] a, logic [31:0] d, logic r);
    logic [15:0] n_ctrl, n_hot, n_mmask, n_mst;
    logic [7:0]  n_imask;
    logic        n_hold;
    @(negedge clk);
    we = w; addr = a; wd = d; rq = r;
    n_ctrl = m_ctrl; n_hot = m_hot; n_mmask = m_mmask; n_imask = m_imask; n_mst = m_mst;
    if (w && a == 12'h000) n_ctrl  = wm(m_ctrl, d, 16'h00F4);
    if (w && a == 12'h180) n_hot   = wm(m_hot, d, 16'h0012);
    if (w && a == 12'h024) n_mmask = wm(m_mmask, d, 16'hFFFF);
    if (w && a == 12'h01C) n_imask = 8'(wm({8'h0, m_imask}, d, 16'h00FF));
    if (w && a == 12'h010) n_mst   = n_mst & ~d[15:0];
    n_mst = (n_mst | {13'h0, r, dl & ~m_prev, 1'b0}) & 16'h0006;
    n_hold = m_hold;
    if (m_hot[1] && r) n_hold = 1'b1;
    else if (w && a == 12'h180 && d[19] && d[3]) n_hold = 1'b0;
    @(posedge clk);
    #1;
    m_ctrl = n_ctrl; m_hot = n_hot; m_mmask = n_mmask; m_imask = n_imask; m_mst = n_mst;
    m_hold = n_hold; m_ix = ix; m_prev = dl;
    check_all();
  endtask

  task automatic rdc(logic [11:0] a);
    cyc(1'b0, a, 32'h0, 1'b0);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rdc(12'h000); chk("R2", rd, 32'h0);
    rdc(12'h024); chk("R5", rd, 32'h0000FFFF);
    rdc(12'h01C); chk("R6", rd, 32'h000000FF);
    rdc(12'h180); chk("R7", rd, 32'h0);
    // write mask
    cyc(1'b1, 12'h000, 32'h00F4_0044, 1'b0); chk("R2", 32'(mode), 32'h4);
    cyc(1'b1, 12'h000, 32'h0000_00B0, 1'b0); chk("R1", rd, 32'h44);
    cyc(1'b1, 12'h000, 32'h0004_0000, 1'b0); chk("R1", rd, 32'h40);
    cyc(1'b1, 12'h000, 32'h0004_0004, 1'b0); chk("R8", 32'(ltssm_en), 32'h1);
    // training status and link edge
    st = 6'h11; phys = 1'b1; dl = 1'b1;
    rdc(12'h300); chk("R3", rd, 32'h0003_0011);
    rdc(12'h010); chk("R4", rd, 32'h2);
    cyc(1'b1, 12'h024, 32'h0002_0000, 1'b0); chk("R5", 32'(mirq), 32'h1);
    cyc(1'b1, 12'h010, 32'h0000_0002, 1'b0); chk("R4", rd, 32'h0);
    // set and clear in one cycle
    cyc(1'b1, 12'h010, 32'h0000_0004, 1'b1); chk("R4", rd, 32'h4);
    cyc(1'b1, 12'h010, 32'h0000_0004, 1'b0); chk("R4", rd, 32'h0);
    // training hold
    cyc(1'b1, 12'h180, 32'h0012_0012, 1'b0);
    cyc(1'b0, 12'h180, 32'h0, 1'b1); chk("R7", 32'(hold), 32'h1);
    chk("R8", 32'(ltssm_en), 32'h0);
    cyc(1'b1, 12'h180, 32'h0008_0000, 1'b0); chk("R7", 32'(hold), 32'h1);
    cyc(1'b1, 12'h180, 32'h0008_0008, 1'b1); chk("R7", 32'(hold), 32'h1);
    cyc(1'b1, 12'h180, 32'h0008_0008, 1'b0); chk("R7", 32'(hold), 32'h0);
    chk("R7", rd, 32'h12);
    cyc(1'b1, 12'h180, 32'h0002_0000, 1'b0);
    cyc(1'b0, 12'h180, 32'h0, 1'b1); chk("R10", 32'(hold), 32'h0);
    // undefined offsets
    rdc(12'h004); chk("R9", rd, 32'h0);
    rdc(12'h200); chk("R9", rd, 32'h0);
    // legacy lines
    ix = 4'b0101;
    cyc(1'b1, 12'h01C, 32'h0001_0000, 1'b0);
    rdc(12'h008); chk("R6", rd, 32'h5);
    chk("R6", 32'(iirq), 32'h1);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      case ($urandom_range(0, 8))
        0: a = 12'h000; 1: a = 12'h008; 2: a = 12'h010; 3: a = 12'h01C;
        4: a = 12'h024; 5: a = 12'h180; 6: a = 12'h300; 7: a = 12'h004;
        default: a = 12'h200;
      endcase
      d = $urandom;
      if ($urandom_range(0, 3) == 0) d[31:16] = 16'hFFFF;
      if ($urandom_range(0, 5) == 0) dl = ~dl;
      if ($urandom_range(0, 7) == 0) ix = 4'($urandom);
      if ($urandom_range(0, 9) == 0) begin phys = ~phys; st = 6'($urandom); end
      cyc($urandom_range(0, 1) == 1, a, d, $urandom_range(0, 7) == 0);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule